// File: doc/BRIEF.md
# Capture/Compare Channel with Toggle Output

This block is one channel that sits beside a shared free-running counter. The counter value and its advance strobe come in from outside. The channel holds one register that plays two roles. In capture operation it records the counter value when the channel input pin changes. In compare operation it holds a value that is checked against the counter. A matching count can raise the channel flag, and it can also invert the channel output pin, which gives a timed edge generator.

Mode bits choose the behaviour:

- Capture runs on a rising edge, a falling edge, or both, of the channel input pin.
- In software-timer operation a match only sets the flag.
- In high-speed output operation a match sets the flag and inverts the output pin.
- With every mode bit clear, the channel is idle.

Software loads the register through a write strobe and clears the flag through a clear strobe. The interrupt request follows the flag and is gated by an enable. Pulse-width operation is not part of this block.

Top module: `ccx_channel`

## Requirements
- R1: With `cap_rise_en` = 1, a 0-to-1 change on `pin_in` copies `cnt_val` into the channel register and sets `flag`. `pin_in` passes through a two-flop synchronizer, so the copied value is the `cnt_val` present at the third rising clock edge after `pin_in` changes; the edge that first samples the new level counts as the first.
- R2: With `cap_fall_en` = 1, a 1-to-0 change on `pin_in` performs the same capture as in R1. With both capture enables set, either change performs it.
- R3: A change on `pin_in` whose direction has its capture enable clear leaves the channel register and `flag` unchanged.
- R4: With `cmp_en` = 1 and `match_en` = 1, a clock edge at which `cnt_tick` = 1 and `cnt_val` equals the channel register sets `flag`. With `cnt_tick` = 0 there is no match, so one counter value gives at most one match event.
- R5: When an R4 match occurs with `toggle_en` = 1, `pin_out` inverts at that edge. `pin_out` holds in every other case, including when `toggle_en` = 1 and `match_en` = 0.
- R6: `flag` stays set until a cycle with `flag_clr` = 1 clears it at the next edge. When a capture or a match happens in the same cycle as a clear, the set wins.
- R7: `irq` is 1 exactly when `flag` = 1 and `int_en` = 1.
- R8: While reset is held, the channel register reads 0, `flag` is 0 and `pin_out` is 1.
- R9: With `reg_wr` = 1, `reg_wdata` is written into the channel register at the next edge and appears on `reg_rdata`. When a capture happens in the same cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_val | input | 16 | Value of the shared counter |
| cnt_tick | input | 1 | Counter advance strobe; a match is evaluated only when this is 1 |
| cap_rise_en | input | 1 | Capture on a rising input edge |
| cap_fall_en | input | 1 | Capture on a falling input edge |
| cmp_en | input | 1 | Compare function enable |
| match_en | input | 1 | A match sets the flag |
| toggle_en | input | 1 | A match inverts the output pin |
| int_en | input | 1 | Interrupt enable for the channel flag |
| pin_in | input | 1 | Asynchronous channel input pin |
| pin_out | output | 1 | Channel output pin, resets high |
| reg_wr | input | 1 | Software write strobe for the channel register |
| reg_wdata | input | 16 | Software write data |
| reg_rdata | output | 16 | Current channel register contents |
| flag_clr | input | 1 | Software clear strobe for the flag |
| flag | output | 1 | Channel event flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input except `pin_in` is synchronous to `clk`. They also assume that `cnt_tick` marks the single cycle in which a given counter value is valid for matching; the block trusts the caller for that meaning and does not check it. The stimulus drives every input just after the falling clock edge. It keeps the bench-driven counter in a narrow 32-value window, and it writes register values from that same window so that matches, toggles and simultaneous set-and-clear cases happen often. `pin_in` is driven at random moments relative to the counter. Directed sections also place a software write in exactly the cycle of a capture, and a flag clear in exactly the cycle of a match.

// File: rtl/ccx_pkg.sv
package ccx_pkg;

   typedef struct packed {
      logic cap_rise;
      logic cap_fall;
      logic cmp;
      logic match;
      logic toggle;
   } ccx_mode_t;

   function automatic logic ccx_capture_fire(input ccx_mode_t m, input logic rise, input logic fall);
      return (m.cap_rise & rise) | (m.cap_fall & fall);
   endfunction

endpackage

// File: rtl/ccx_edge_detect.sv
module ccx_edge_detect #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ccx_edge_detect: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~last_q;
   assign fall_o = ~sync_q[STAGES-1] & last_q;

   AST_ONE_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R1
   AST_ONE_FALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o); // R2

endmodule

// File: rtl/ccx_capture_reg.sv
module ccx_capture_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap_i,
   input  logic [W-1:0] cnt_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] val_o
);

   if (W < 2) begin : g_bad_width
      $error("ccx_capture_reg: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     val_o <= '0;
      else if (cap_i) val_o <= cnt_i;
      else if (wr_i)  val_o <= wdata_i;
   end

   AST_CAP_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> val_o == $past(cnt_i)); // R1
   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !cap_i) |=> val_o == $past(wdata_i)); // R9

endmodule

// File: rtl/ccx_match_unit.sv
module ccx_match_unit
   import ccx_pkg::*;
#(
   parameter int W = 16
) (
   input  ccx_mode_t    mode_i,
   input  logic [W-1:0] cnt_i,
   input  logic         tick_i,
   input  logic [W-1:0] ref_i,
   output logic         hit_o,
   output logic         flip_o
);

   logic equal;

   assign equal  = (cnt_i == ref_i);
   assign hit_o  = mode_i.cmp & mode_i.match & tick_i & equal;
   assign flip_o = hit_o & mode_i.toggle;

endmodule

// File: rtl/ccx_flag_out.sv
module ccx_flag_out #(
   parameter logic OUT_INIT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic flip_i,
   input  logic int_en_i,
   output logic flag_o,
   output logic pin_o,
   output logic irq_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         pin_o  <= OUT_INIT;
      end else begin
         if (set_i)      flag_o <= 1'b1;
         else if (clr_i) flag_o <= 1'b0;
         if (flip_i)     pin_o  <= ~pin_o;
      end
   end

   assign irq_o = flag_o & int_en_i;

   AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o); // R6
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o); // R6
   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o); // R6
   AST_PIN_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      flip_i |=> pin_o != $past(pin_o)); // R5
   AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !flip_i |=> $stable(pin_o)); // R5

endmodule

// File: rtl/ccx_channel.sv
module ccx_channel
   import ccx_pkg::*;
#(
   parameter int   CNT_W       = 16,
   parameter int   SYNC_STAGES = 2,
   parameter logic OUT_INIT    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             cnt_tick,
   input  logic             cap_rise_en,
   input  logic             cap_fall_en,
   input  logic             cmp_en,
   input  logic             match_en,
   input  logic             toggle_en,
   input  logic             int_en,
   input  logic             pin_in,
   output logic             pin_out,
   input  logic             reg_wr,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   input  logic             flag_clr,
   output logic             flag,
   output logic             irq
);

   ccx_mode_t mode;
   logic      rise, fall, cap_fire, hit, flip;

   assign mode.cap_rise = cap_rise_en;
   assign mode.cap_fall = cap_fall_en;
   assign mode.cmp      = cmp_en;
   assign mode.match    = match_en;
   assign mode.toggle   = toggle_en;

   ccx_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .rise_o(rise), .fall_o(fall)
   );

   assign cap_fire = ccx_capture_fire(mode, rise, fall);

   ccx_capture_reg #(.W(CNT_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .cap_i(cap_fire), .cnt_i(cnt_val),
      .wr_i(reg_wr), .wdata_i(reg_wdata), .val_o(reg_rdata)
   );

   ccx_match_unit #(.W(CNT_W)) u_match (
      .mode_i(mode), .cnt_i(cnt_val), .tick_i(cnt_tick), .ref_i(reg_rdata),
      .hit_o(hit), .flip_o(flip)
   );

   ccx_flag_out #(.OUT_INIT(OUT_INIT)) u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(cap_fire | hit), .clr_i(flag_clr),
      .flip_i(flip), .int_en_i(int_en), .flag_o(flag), .pin_o(pin_out), .irq_o(irq)
   );

   AST_IDLE_REG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_rise_en && !cap_fall_en && !reg_wr) |=> $stable(reg_rdata)); // R3
   AST_MATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && match_en && cnt_tick && cnt_val == reg_rdata) |=> flag); // R4
   AST_NO_TICK_NO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_tick |=> $stable(pin_out)); // R5

endmodule

// File: tb/ccx_channel_test.sv
`timescale 1ns/1ps
module ccx_channel_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt_val = '0;
   logic        cnt_tick = 1'b0;
   logic        cap_rise_en = 1'b0, cap_fall_en = 1'b0, cmp_en = 1'b0;
   logic        match_en = 1'b0, toggle_en = 1'b0, int_en = 1'b0;
   logic        pin_in = 1'b0, reg_wr = 1'b0, flag_clr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic        pin_out, flag, irq;
   logic [15:0] reg_rdata;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   bit chk_on   = 1'b0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   ccx_channel uut (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
      .cap_rise_en(cap_rise_en), .cap_fall_en(cap_fall_en), .cmp_en(cmp_en),
      .match_en(match_en), .toggle_en(toggle_en), .int_en(int_en),
      .pin_in(pin_in), .pin_out(pin_out), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .flag_clr(flag_clr), .flag(flag), .irq(irq)
   );

   // Reference model built from the requirements
   logic [1:0]  ms;
   logic        mlast;
   logic [15:0] m_reg;
   logic        m_flag, m_pin;

   function automatic logic f_capture(input logic s, input logic last,
                                      input logic cr, input logic cf);
      return (cr & s & ~last) | (cf & ~s & last);   // R1 R2
   endfunction

   function automatic logic f_match(input logic ce, input logic me, input logic tk,
                                    input logic [15:0] c, input logic [15:0] r);
      return ce & me & tk & (c == r);                // R4
   endfunction

   always @(posedge clk) begin
      logic cap, hit;
      if (!rst_n) begin
         ms <= '0; mlast <= 1'b0; m_reg <= '0; m_flag <= 1'b0; m_pin <= 1'b1;
      end else begin
         cap = f_capture(ms[1], mlast, cap_rise_en, cap_fall_en);
         hit = f_match(cmp_en, match_en, cnt_tick, cnt_val, m_reg);
         ms    <= {ms[0], pin_in};
         mlast <= ms[1];
         if (cap)         m_reg <= cnt_val;
         else if (reg_wr) m_reg <= reg_wdata;
         if (cap | hit)   m_flag <= 1'b1;
         else if (flag_clr) m_flag <= 1'b0;
         if (hit & toggle_en) m_pin <= ~m_pin;
      end
   end

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   endtask

   always @(negedge clk) begin
      if (chk_on && rst_n) begin
         check("R1 register", reg_rdata, m_reg);
         check("R6 flag", {15'd0, flag}, {15'd0, m_flag});
         check("R5 pin_out", {15'd0, pin_out}, {15'd0, m_pin});
         check("R7 irq", {15'd0, irq}, {15'd0, m_flag & int_en});
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 200000) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer than 200000", cyc);
         finish_run();
      end
   end

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_flag();
      #1 flag_clr = 1'b1;
      waitn(1);
      #1 flag_clr = 1'b0;
   endtask

   initial begin
      logic [15:0] cq;
      void'($urandom(32'd20240611));

      // R8: reset state
      int_en = 1'b1;
      waitn(3);
      check("R8 reset register", reg_rdata, 16'h0000);
      check("R8 reset flag", {15'd0, flag}, 16'h0000);
      check("R8 reset pin_out", {15'd0, pin_out}, 16'h0001);
      check("R8 reset irq", {15'd0, irq}, 16'h0000);
      #1 rst_n = 1'b1; int_en = 1'b0; chk_on = 1'b1;
      waitn(2);

      // R1: rising capture
      #1 cap_rise_en = 1'b1; cnt_val = 16'h1234; pin_in = 1'b1;
      waitn(4);
      check("R1 captured value", reg_rdata, 16'h1234);
      check("R1 flag after capture", {15'd0, flag}, 16'h0001);
      // R3: falling edge with only rise enabled
      #1 cnt_val = 16'h5555; pin_in = 1'b0;
      waitn(4);
      check("R3 falling ignored", reg_rdata, 16'h1234);
      clear_flag();

      // R2: falling capture
      #1 cap_rise_en = 1'b0; cap_fall_en = 1'b1; cnt_val = 16'hBEEF; pin_in = 1'b1;
      waitn(4);
      check("R3 rising ignored reg", reg_rdata, 16'h1234);
      check("R3 rising ignored flag", {15'd0, flag}, 16'h0000);
      #1 pin_in = 1'b0;
      waitn(4);
      check("R2 falling capture", reg_rdata, 16'hBEEF);
      check("R2 flag", {15'd0, flag}, 16'h0001);
      clear_flag();
      #1 cap_rise_en = 1'b1; cnt_val = 16'h0F0F; pin_in = 1'b1;
      waitn(4);
      check("R2 both enables rise", reg_rdata, 16'h0F0F);
      #1 cnt_val = 16'h7007; pin_in = 1'b0;
      waitn(4);
      check("R2 both enables fall", reg_rdata, 16'h7007);
      clear_flag();

      // R3: capture disabled
      #1 cap_rise_en = 1'b0; cap_fall_en = 1'b0; cnt_val = 16'hAAAA; pin_in = 1'b1;
      waitn(4);
      #1 pin_in = 1'b0;
      waitn(4);
      check("R3 idle register", reg_rdata, 16'h7007);
      check("R3 idle flag", {15'd0, flag}, 16'h0000);

      // R9: software write, then write colliding with capture
      #1 reg_wr = 1'b1; reg_wdata = 16'h00C8;
      waitn(1);
      #1 reg_wr = 1'b0;
      check("R9 write", reg_rdata, 16'h00C8);
      #1 cap_rise_en = 1'b1; cnt_val = 16'h4444; pin_in = 1'b1;
      waitn(2);
      #1 reg_wr = 1'b1; reg_wdata = 16'h3333;
      waitn(1);
      check("R9 capture beats write", reg_rdata, 16'h4444);
      #1 reg_wr = 1'b0; cap_rise_en = 1'b0; pin_in = 1'b0;
      waitn(4);
      clear_flag();
      #1 reg_wr = 1'b1; reg_wdata = 16'h00C8;
      waitn(1);
      #1 reg_wr = 1'b0;

      // R4: match only on tick
      #1 cmp_en = 1'b1; match_en = 1'b1; cnt_val = 16'h00C8; cnt_tick = 1'b0;
      waitn(3);
      check("R4 no tick no match", {15'd0, flag}, 16'h0000);
      #1 cnt_tick = 1'b1;
      waitn(1);
      #1 cnt_tick = 1'b0;
      check("R4 match sets flag", {15'd0, flag}, 16'h0001);
      check("R4 no toggle without toggle_en", {15'd0, pin_out}, 16'h0001);
      clear_flag();

      // R5: toggle on match
      #1 toggle_en = 1'b1; cnt_tick = 1'b1;
      waitn(1);
      check("R5 toggle on match", {15'd0, pin_out}, 16'h0000);
      #1 cnt_val = 16'h00C9;
      waitn(1);
      check("R5 no toggle off match", {15'd0, pin_out}, 16'h0000);
      #1 match_en = 1'b0; cnt_val = 16'h00C8;
      waitn(1);
      check("R5 no toggle without match_en", {15'd0, pin_out}, 16'h0000);
      #1 match_en = 1'b1;
      waitn(1);
      check("R5 toggle back", {15'd0, pin_out}, 16'h0001);

      // R6: set beats clear, clear alone clears
      #1 toggle_en = 1'b0; flag_clr = 1'b1;
      waitn(1);
      check("R6 set wins over clear", {15'd0, flag}, 16'h0001);
      #1 cnt_tick = 1'b0;
      waitn(1);
      check("R6 clear", {15'd0, flag}, 16'h0000);

      // R7: interrupt gating
      #1 flag_clr = 1'b0; int_en = 1'b0; cnt_tick = 1'b1;
      waitn(1);
      #1 cnt_tick = 1'b0;
      check("R7 irq masked", {15'd0, irq}, 16'h0000);
      #1 int_en = 1'b1;
      waitn(1);
      check("R7 irq raised", {15'd0, irq}, 16'h0001);
      #1 cmp_en = 1'b0; match_en = 1'b0;
      clear_flag();

      // Random phase
      cq = '0;
      for (int i = 0; i < 4000; i++) begin
         #1;
         if (i % 64 == 0) begin
            cap_rise_en = 1'($urandom);
            cap_fall_en = 1'($urandom);
            cmp_en      = ($urandom % 4) != 0;
            match_en    = ($urandom % 4) != 0;
            toggle_en   = 1'($urandom);
            int_en      = 1'($urandom);
         end
         cnt_tick  = ($urandom % 3) != 0;
         cnt_val   = cq;
         cq        = (cq + {15'd0, cnt_tick}) & 16'h001F;
         if ($urandom % 4 == 0) pin_in = ~pin_in;
         reg_wr    = ($urandom % 16) == 0;
         reg_wdata = 16'($urandom % 32);
         flag_clr  = ($urandom % 8) == 0;
         waitn(1);
      end
      #1 cnt_tick = 1'b0; reg_wr = 1'b0; flag_clr = 1'b0;
      waitn(2);
      finish_run();
   end

endmodule